// File: doc/BRIEF.md
# Register-Programmable Clock Divider

This block divides one input clock by a ratio held in a bit field of a 32-bit control register. Two parameters place the field: a shift gives its lowest bit and a width gives its size. The field is decoded under one of five encodings, selected at elaboration. The result drives a period counter, which produces two outputs: a divided clock level and a one-cycle enable strobe that marks the last input cycle of each output period. The divisor that is currently in force is visible on its own port.

Software writes the control register through a simple write strobe. Two options change how writes behave. In masked mode, the upper 16 bits of each written word act as per-bit write enables for the lower 16 bits. In locked mode, the register keeps its reset value and ignores every write. A new ratio waits until the running output period ends, so the output never shows a shortened pulse. A field value that cannot be decoded leaves the last good ratio in place and raises an error flag.

Top module: `clkdiv_prog`

## Requirements
- R1: In the plus-one encoding (MODE DM_PLUS1), the divisor is the field value plus one.
- R2: In the one-based encoding (DM_ONE) without zero permitted, the divisor is the field value. A zero field is invalid: the previous valid divisor stays in force and `dec_err` reads 1. A later valid field clears `dec_err` to 0.
- R3: In the one-based encoding with ALLOW_ZERO=1, a zero field gives a divisor of 1 and no error.
- R4: In the power-of-two encoding (DM_POW2), the divisor is 2 raised to the field value.
- R5: In the max-at-zero encoding (DM_MAXZ), a nonzero field is used as the divisor directly, and a zero field gives 2^WIDTH.
- R6: In the table encoding (DM_TABLE), entries are searched from index 0 upward. The first entry whose value matches the field supplies the divisor. An entry whose divisor is 0 ends the search, so entries after it are never used. A field with no match before the end is invalid and is handled as in R2.
- R7: With HIWORD=1, bit k of the register (k < 16) takes bit k of the written word only when bit k+16 of that word is 1. The register's upper 16 bits always read 0.
- R8: With READ_ONLY=1, writes have no effect. `rd_data` keeps its reset value, and so does the divisor decoded from it.
- R9: The divisor shown on `divisor` changes only on the clock edge that follows a cycle in which `clk_en` was 1. A newly written ratio therefore never cuts the current output period short.
- R10: For a divisor D, `clk_div` is 1 for floor(D/2) input cycles and 0 for the rest of each period. `clk_en` is 1 once per period, in the last cycle, and `clk_div` is 0 in that cycle.
- R11: While in reset, `rd_data` equals RST_CTRL, `divisor` is 1, `clk_en` is 1 and `dec_err` is 0. After reset, the decoded reset field takes over within a few cycles.
- R12: Only bits [SHIFT+WIDTH-1:SHIFT] affect the decode. Other register bits are stored and read back but do not change the divisor. By default SHIFT=4 and WIDTH=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 32 | Word written to the control register |
| rd_data | output | 32 | Current control register contents |
| divisor | output | DIV_W | Divisor currently in force |
| clk_div | output | 1 | Divided clock level |
| clk_en | output | 1 | One-cycle strobe in the last cycle of each period |
| dec_err | output | 1 | Last decode of the field was invalid |

## Verification
The bench covers the zero field in every encoding where zero means something different:
- A design that lets an invalid zero through would show a divisor of 0, or of 1.
- A design that confuses max-at-zero with bypass would show 1 instead of 16.

Table decode is tested with a value that sits after the terminating entry. A search that does not stop at the terminator would return 9 for that value. The masked write is tested with a partial mask, and with a mask of zero that must change nothing. The ratio-update test writes a short ratio in the middle of a long period. A design that reloads at once would show the new divisor before the period-end strobe. The duty-cycle counts over whole periods catch an off-by-one in the high phase for odd divisors.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
   typedef enum logic [2:0] {
      DM_PLUS1 = 3'd0,
      DM_ONE   = 3'd1,
      DM_POW2  = 3'd2,
      DM_MAXZ  = 3'd3,
      DM_TABLE = 3'd4
   } div_mode_e;

   localparam int TBL_ENT_W = 16;
   localparam int TBL_N_DEF = 5;
   // Entry 0 is the lowest slice. Entry 3 has divisor 0 and ends the list.
   localparam logic [TBL_N_DEF-1:0][TBL_ENT_W-1:0] TBL_VAL_DEF =
      {16'd5, 16'd4, 16'd2, 16'd1, 16'd0};
   localparam logic [TBL_N_DEF-1:0][TBL_ENT_W-1:0] TBL_DIV_DEF =
      {16'd9, 16'd0, 16'd7, 16'd5, 16'd3};
endpackage

// File: rtl/cdiv_ctrl_reg.sv
module cdiv_ctrl_reg #(
   parameter bit          HIWORD    = 1'b0,
   parameter bit          READ_ONLY = 1'b0,
   parameter logic [31:0] RST_CTRL  = 32'h0000_0030
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [31:0] wr_data,
   output logic [31:0] ctrl
);
   localparam int HALF = 16;

   logic [31:0] ctrl_q;
   logic [31:0] ctrl_nx;

   generate
      if (READ_ONLY) begin : g_locked
         assign ctrl_nx = ctrl_q;
      end else if (HIWORD) begin : g_masked
         logic [HALF-1:0] bit_we;
         assign bit_we  = wr_data[2*HALF-1:HALF];
         assign ctrl_nx = {{HALF{1'b0}},
                           (ctrl_q[HALF-1:0] & ~bit_we) | (wr_data[HALF-1:0] & bit_we)};
      end else begin : g_plain
         assign ctrl_nx = wr_data;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= RST_CTRL;
      end else if (wr_en) begin
         ctrl_q <= ctrl_nx;
      end
   end

   assign ctrl = ctrl_q;
endmodule

// File: rtl/cdiv_decode.sv
module cdiv_decode
   import clkdiv_pkg::*;
#(
   parameter div_mode_e MODE       = DM_PLUS1,
   parameter bit        ALLOW_ZERO = 1'b0,
   parameter int        WIDTH      = 4,
   parameter int        DIV_W      = 16,
   parameter int        TBL_N      = TBL_N_DEF,
   parameter logic [TBL_N-1:0][TBL_ENT_W-1:0] TBL_VAL = TBL_VAL_DEF,
   parameter logic [TBL_N-1:0][TBL_ENT_W-1:0] TBL_DIV = TBL_DIV_DEF
) (
   input  logic [WIDTH-1:0] field,
   output logic [DIV_W-1:0] div,
   output logic             valid
);
   localparam logic [DIV_W-1:0] ONE_D = DIV_W'(1);
   localparam logic [DIV_W-1:0] TOP_D = DIV_W'(1) << WIDTH;

   generate
      if (MODE == DM_PLUS1) begin : g_plus1
         assign div   = DIV_W'(field) + ONE_D;
         assign valid = 1'b1;
      end else if (MODE == DM_ONE) begin : g_one
         assign div   = (field == '0) ? ONE_D : DIV_W'(field);
         assign valid = (field != '0) || ALLOW_ZERO;
      end else if (MODE == DM_POW2) begin : g_pow2
         assign div   = ONE_D << field;
         assign valid = 1'b1;
      end else if (MODE == DM_MAXZ) begin : g_maxz
         assign div   = (field == '0) ? TOP_D : DIV_W'(field);
         assign valid = 1'b1;
      end else begin : g_table
         always_comb begin
            logic stop;
            stop  = 1'b0;
            div   = ONE_D;
            valid = 1'b0;
            for (int i = 0; i < TBL_N; i++) begin
               if (!stop) begin
                  if (TBL_DIV[i] == '0) begin
                     stop = 1'b1;
                  end else if (TBL_VAL[i] == TBL_ENT_W'(field)) begin
                     div   = DIV_W'(TBL_DIV[i]);
                     valid = 1'b1;
                     stop  = 1'b1;
                  end
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/cdiv_period.sv
module cdiv_period #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] next_div,
   output logic [DIV_W-1:0] active_div,
   output logic             clk_div,
   output logic             clk_en
);
   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] act_q;
   logic             out_q;
   logic             wrap;
   logic [DIV_W-1:0] cnt_inc;

   assign wrap    = (cnt_q == act_q - DIV_W'(1));
   assign cnt_inc = cnt_q + DIV_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         act_q <= DIV_W'(1);
         out_q <= 1'b0;
      end else if (wrap) begin
         cnt_q <= '0;
         act_q <= next_div;
         out_q <= ((next_div >> 1) != '0);
      end else begin
         cnt_q <= cnt_inc;
         out_q <= (cnt_inc < (act_q >> 1));
      end
   end

   assign active_div = act_q;
   assign clk_div    = out_q;
   assign clk_en     = wrap;
endmodule

// File: rtl/clkdiv_prog.sv
module clkdiv_prog
   import clkdiv_pkg::*;
#(
   parameter div_mode_e   MODE       = DM_PLUS1,
   parameter bit          ALLOW_ZERO = 1'b0,
   parameter bit          HIWORD     = 1'b0,
   parameter bit          READ_ONLY  = 1'b0,
   parameter int          SHIFT      = 4,
   parameter int          WIDTH      = 4,
   parameter int          DIV_W      = 16,
   parameter logic [31:0] RST_CTRL   = 32'h0000_0030,
   parameter int          TBL_N      = TBL_N_DEF,
   parameter logic [TBL_N-1:0][TBL_ENT_W-1:0] TBL_VAL = TBL_VAL_DEF,
   parameter logic [TBL_N-1:0][TBL_ENT_W-1:0] TBL_DIV = TBL_DIV_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [31:0]      wr_data,
   output logic [31:0]      rd_data,
   output logic [DIV_W-1:0] divisor,
   output logic             clk_div,
   output logic             clk_en,
   output logic             dec_err
);
   localparam int FIELD_TOP = SHIFT + WIDTH;
   localparam int REG_LIM   = HIWORD ? 16 : 32;

   if (WIDTH < 1 || FIELD_TOP > REG_LIM) begin : g_bad_field
      $error("divider field does not fit the writable register bits");
   end
   if (MODE == DM_POW2 && ((1 << WIDTH) - 1) >= DIV_W) begin : g_bad_pow2
      $error("DIV_W too small for power-of-two decode");
   end
   if (WIDTH >= DIV_W) begin : g_bad_divw
      $error("DIV_W must exceed WIDTH");
   end

   logic [31:0]      ctrl;
   logic [WIDTH-1:0] field;
   logic [DIV_W-1:0] dec_div;
   logic             dec_ok;
   logic [DIV_W-1:0] pend_q;
   logic             err_q;

   cdiv_ctrl_reg #(
      .HIWORD   (HIWORD),
      .READ_ONLY(READ_ONLY),
      .RST_CTRL (RST_CTRL)
   ) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_data(wr_data),
      .ctrl   (ctrl)
   );

   assign field = ctrl[SHIFT +: WIDTH];

   cdiv_decode #(
      .MODE      (MODE),
      .ALLOW_ZERO(ALLOW_ZERO),
      .WIDTH     (WIDTH),
      .DIV_W     (DIV_W),
      .TBL_N     (TBL_N),
      .TBL_VAL   (TBL_VAL),
      .TBL_DIV   (TBL_DIV)
   ) u_dec (
      .field(field),
      .div  (dec_div),
      .valid(dec_ok)
   );

   // Last good ratio waits here until the running period ends.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= DIV_W'(1);
         err_q  <= 1'b0;
      end else begin
         err_q <= !dec_ok;
         if (dec_ok) begin
            pend_q <= dec_div;
         end
      end
   end

   cdiv_period #(
      .DIV_W(DIV_W)
   ) u_per (
      .clk       (clk),
      .rst_n     (rst_n),
      .next_div  (pend_q),
      .active_div(divisor),
      .clk_div   (clk_div),
      .clk_en    (clk_en)
   );

   assign rd_data = ctrl;
   assign dec_err = err_q;
endmodule

// File: rtl/clkdiv_prog_chk.sv
module clkdiv_prog_chk #(
   parameter bit HIWORD    = 1'b0,
   parameter bit READ_ONLY = 1'b0,
   parameter int DIV_W     = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [31:0]      rd_data,
   input logic [DIV_W-1:0] divisor,
   input logic             clk_div,
   input logic             clk_en
);
   AST_RATIO_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(divisor) |-> $past(clk_en)); // R9
   AST_EN_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en |-> !clk_div); // R10
   AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      divisor != '0); // R2
   AST_HIWORD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      HIWORD |-> (rd_data[31:16] == 16'h0)); // R7
   AST_RO_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      READ_ONLY |=> $stable(rd_data)); // R8
endmodule

bind clkdiv_prog clkdiv_prog_chk #(
   .HIWORD   (HIWORD),
   .READ_ONLY(READ_ONLY),
   .DIV_W    (DIV_W)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .rd_data(rd_data),
   .divisor(divisor),
   .clk_div(clk_div),
   .clk_en (clk_en)
);

// File: tb/clkdiv_prog_bench.sv
`timescale 1ns/1ps
module clkdiv_prog_bench;
   import clkdiv_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] wd = '0;
   logic [6:0]  we = '0;
   logic [31:0] rd [7];
   logic [15:0] dv [7];
   logic [6:0]  er, cd, ce;
   int          n_chk = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   clkdiv_prog u_clkdiv_prog (.clk(clk), .rst_n(rst_n), .wr_en(we[0]), .wr_data(wd),
      .rd_data(rd[0]), .divisor(dv[0]), .clk_div(cd[0]), .clk_en(ce[0]), .dec_err(er[0]));
   clkdiv_prog #(.MODE(DM_ONE), .HIWORD(1'b1)) u_one (.clk(clk), .rst_n(rst_n),
      .wr_en(we[1]), .wr_data(wd), .rd_data(rd[1]), .divisor(dv[1]), .clk_div(cd[1]),
      .clk_en(ce[1]), .dec_err(er[1]));
   clkdiv_prog #(.MODE(DM_ONE), .ALLOW_ZERO(1'b1)) u_onez (.clk(clk), .rst_n(rst_n),
      .wr_en(we[2]), .wr_data(wd), .rd_data(rd[2]), .divisor(dv[2]), .clk_div(cd[2]),
      .clk_en(ce[2]), .dec_err(er[2]));
   clkdiv_prog #(.MODE(DM_POW2)) u_pow2 (.clk(clk), .rst_n(rst_n),
      .wr_en(we[3]), .wr_data(wd), .rd_data(rd[3]), .divisor(dv[3]), .clk_div(cd[3]),
      .clk_en(ce[3]), .dec_err(er[3]));
   clkdiv_prog #(.MODE(DM_MAXZ)) u_maxz (.clk(clk), .rst_n(rst_n),
      .wr_en(we[4]), .wr_data(wd), .rd_data(rd[4]), .divisor(dv[4]), .clk_div(cd[4]),
      .clk_en(ce[4]), .dec_err(er[4]));
   clkdiv_prog #(.MODE(DM_TABLE), .RST_CTRL(32'h0)) u_tbl (.clk(clk), .rst_n(rst_n),
      .wr_en(we[5]), .wr_data(wd), .rd_data(rd[5]), .divisor(dv[5]), .clk_div(cd[5]),
      .clk_en(ce[5]), .dec_err(er[5]));
   clkdiv_prog #(.READ_ONLY(1'b1)) u_ro (.clk(clk), .rst_n(rst_n),
      .wr_en(we[6]), .wr_data(wd), .rd_data(rd[6]), .divisor(dv[6]), .clk_div(cd[6]),
      .clk_en(ce[6]), .dec_err(er[6]));

   typedef struct packed {
      logic [2:0]  inst;
      logic [31:0] data;
      logic [15:0] div;
      logic        err;
      logic [31:0] rdv;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 19;
   // Field sits at bits [7:4]. req: R1 plus-one, R2 one-based zero, R3 allow-zero,
   // R4 pow2, R5 max-at-zero, R6 table, R7 masked write, R8 locked, R12 field position.
   localparam vec_t VEC [NV] = '{
      '{3'd0, 32'h0000_0050, 16'd6,  1'b0, 32'h0000_0050, 4'd1},
      '{3'd0, 32'h0000_00F0, 16'd16, 1'b0, 32'h0000_00F0, 4'd1},
      '{3'd0, 32'h0000_FF0F, 16'd1,  1'b0, 32'h0000_FF0F, 4'd12},
      '{3'd1, 32'h00F0_0050, 16'd5,  1'b0, 32'h0000_0050, 4'd7},
      '{3'd1, 32'h0000_0070, 16'd5,  1'b0, 32'h0000_0050, 4'd7},
      '{3'd1, 32'h00F0_0000, 16'd5,  1'b1, 32'h0000_0000, 4'd2},
      '{3'd1, 32'h00F0_0020, 16'd2,  1'b0, 32'h0000_0020, 4'd2},
      '{3'd1, 32'h0010_0010, 16'd3,  1'b0, 32'h0000_0030, 4'd7},
      '{3'd2, 32'h0000_0000, 16'd1,  1'b0, 32'h0000_0000, 4'd3},
      '{3'd2, 32'h0000_0070, 16'd7,  1'b0, 32'h0000_0070, 4'd3},
      '{3'd3, 32'h0000_0050, 16'd32, 1'b0, 32'h0000_0050, 4'd4},
      '{3'd3, 32'h0000_0000, 16'd1,  1'b0, 32'h0000_0000, 4'd4},
      '{3'd4, 32'h0000_0000, 16'd16, 1'b0, 32'h0000_0000, 4'd5},
      '{3'd4, 32'h0000_0090, 16'd9,  1'b0, 32'h0000_0090, 4'd5},
      '{3'd5, 32'h0000_0010, 16'd5,  1'b0, 32'h0000_0010, 4'd6},
      '{3'd5, 32'h0000_0030, 16'd5,  1'b1, 32'h0000_0030, 4'd6},
      '{3'd5, 32'h0000_0020, 16'd7,  1'b0, 32'h0000_0020, 4'd6},
      '{3'd5, 32'h0000_0050, 16'd7,  1'b1, 32'h0000_0050, 4'd6},
      '{3'd6, 32'h0000_00F0, 16'd4,  1'b0, 32'h0000_0030, 4'd8}
   };

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic write(input int idx, input logic [31:0] data);
      @(negedge clk);
      wd = data;
      we[idx] = 1'b1;
      @(negedge clk);
      we = '0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic duty(input logic [31:0] data, input int d, input string req);
      int hi;
      int en;
      write(0, data);
      idle(80);
      hi = 0;
      en = 0;
      for (int i = 0; i < 10 * d; i++) begin
         @(negedge clk);
         if (cd[0]) hi++;
         if (ce[0]) en++;
      end
      check(hi == 10 * (d / 2), req, "high cycles over 10 periods", hi, 10 * (d / 2));
      check(en == 10, req, "strobes over 10 periods", en, 10);
   endtask

   initial begin : watchdog
      int cyc;
      cyc = 0;
      while (!done && cyc < 150000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected done", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      idle(4);
      // R11 reset state
      check(rd[0] == 32'h30, "R11", "rd_data in reset", rd[0], 32'h30);
      check(dv[0] == 16'd1, "R11", "divisor in reset", dv[0], 1);
      check(ce[0] == 1'b1, "R11", "clk_en in reset", ce[0], 1);
      check(er[0] == 1'b0, "R11", "dec_err in reset", er[0], 0);
      @(negedge clk);
      rst_n = 1'b1;
      idle(10);
      check(dv[0] == 16'd4, "R11", "plus-one reset field", dv[0], 4);
      check(dv[5] == 16'd3, "R11", "table reset field", dv[5], 3);
      check(er[5] == 1'b0, "R11", "table reset err", er[5], 0);
      check(dv[6] == 16'd4, "R8", "locked reset divisor", dv[6], 4);

      for (int v = 0; v < NV; v++) begin
         write(int'(VEC[v].inst), VEC[v].data);
         idle(80);
         check(dv[VEC[v].inst] == VEC[v].div, $sformatf("R%0d", VEC[v].req),
               $sformatf("vector %0d divisor", v), dv[VEC[v].inst], VEC[v].div);
         check(er[VEC[v].inst] == VEC[v].err, $sformatf("R%0d", VEC[v].req),
               $sformatf("vector %0d dec_err", v), er[VEC[v].inst], VEC[v].err);
         check(rd[VEC[v].inst] == VEC[v].rdv, $sformatf("R%0d", VEC[v].req),
               $sformatf("vector %0d rd_data", v), rd[VEC[v].inst], VEC[v].rdv);
      end

      // R9: a short ratio written mid-period waits for the period end
      write(0, 32'h0000_00F0);
      idle(80);
      while (!ce[0]) @(negedge clk);
      idle(3);
      write(0, 32'h0000_0010);
      idle(4);
      check(dv[0] == 16'd16, "R9", "divisor before period end", dv[0], 16);
      while (!ce[0]) @(negedge clk);
      check(dv[0] == 16'd16, "R9", "divisor during last cycle", dv[0], 16);
      @(negedge clk);
      check(dv[0] == 16'd2, "R9", "divisor after period end", dv[0], 2);

      // R10 duty cycle, even and odd
      duty(32'h0000_0050, 6, "R10");
      duty(32'h0000_0040, 5, "R10");
      duty(32'h0000_0060, 7, "R10");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule